// File: doc/BRIEF.md
# Channel-Tagged Sample Merger

This block gathers samples from several acquisition channels and pulses from a GPS one-pulse-per-second line, and merges them into one stream of 64-bit words for a single transfer channel toward a host. Each word is self-describing: its upper 32 bits name where it came from and its lower 32 bits carry the value. The host sorts words by identifier and counts each channel's words between consecutive pulse markers to obtain that channel's sample rate.

Each channel has a fixed sample width set by a parameter. Narrow samples are sign-extended into the 32-bit value field. A 64-bit channel produces a pair of words, high half first, which are never separated by any other word. Every channel has a one-entry holding slot. A sample offered while the slot is occupied is discarded and marks that channel's sticky overflow bit. A parameter selects fixed-priority or round-robin arbitration between channels.

Top module: `tagged_sample_merger`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0, every `ch_ready` bit is 1 and every `ovf` bit is 0.
- R2: An output word is {identifier[31:0], value[31:0]} on `out_data[63:32]` and `out_data[31:0]`. A sample from channel index i (counting from 0) carries identifier i+1. The pulse marker carries identifier 0.
- R3: A channel of width W below 32 places the sign-extension of `ch_data` bits [W-1:0] in the value field. A 32-bit channel is passed unchanged. Input bits at or above W have no effect.
- R4: A 64-bit channel i emits two words back to back. The first is {i+1, bits 63:32} and the second is {i+1+LOW_ID_OFS, bits 31:0}, with LOW_ID_OFS defaulting to 128. No other word is accepted between them.
- R5: Each rising edge of `pps_in`, seen after a two-flop synchroniser, emits exactly one marker whose value is the number of rising edges since reset (1 for the first). A level held high emits one marker only.
- R6: A pending marker is emitted before any pending channel sample. The exception is a pending low half of a 64-bit pair, which is emitted first.
- R7: With ARB_RR=0, among pending channels the lowest index is always emitted first.
- R8: With ARB_RR=1, after channel g is emitted the search for the next channel starts at g+1 and wraps around.
- R9: `ch_ready[i]` is 1 exactly when channel i's holding slot is empty. A sample presented with `ch_valid[i]` while it is 1 is emitted later.
- R10: A sample presented while `ch_ready[i]` is 0 is discarded and sets `ovf[i]`. That bit stays 1 until reset, and the other channels' bits do not change.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_valid | input | NUM_CH | Per-channel sample strobe |
| ch_ready | output | NUM_CH | Per-channel holding slot empty |
| ch_data | input | NUM_CH*64 | Per-channel sample, channel i at bits [64*i+63:64*i] |
| pps_in | input | 1 | Asynchronous pulse-per-second line |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 64 | Tagged output word |
| ovf | output | NUM_CH | Sticky per-channel discard flags |

## Verification
The narrow channels are driven with negative values and with junk in their unused upper bits, so that correct sign extension can be told apart from zero extension and from leaking input bits. The output is stalled while several sources become pending. The resulting order separates fixed priority from round-robin, shows the marker overtaking channel samples, and shows that the marker does not overtake the second half of a 64-bit pair. A long high pulse on the pulse line distinguishes edge detection from level detection. A third sample is written into a full slot and must disappear from the stream and leave only its own channel's overflow bit set.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned WIDTH_FIELD_W = 7;

  typedef struct packed {
    logic [HALF_W-1:0] tag;
    logic [HALF_W-1:0] value;
  } tagged_word_t;
endpackage

// File: rtl/tsm_pps_detect.sv
module tsm_pps_detect #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pps_in,
  input  logic             taken,
  output logic             pend,
  output logic [CNT_W-1:0] count
);
  logic [2:0] sync_q;
  logic       rise;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], pps_in};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      count <= '0;
    end else if (rise) begin
      pend  <= 1'b1;
      count <= count + 1'b1;
    end else if (taken) begin
      pend  <= 1'b0;
    end
  end
endmodule

// File: rtl/tsm_slot.sv
module tsm_slot #(
  parameter int unsigned W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [63:0] in_data,
  input  logic        drain,
  output logic        ready,
  output logic        full,
  output logic [63:0] val,
  output logic        ovf
);
  logic [63:0] ext;

  generate
    if (W >= 64) begin : g_wide
      assign ext = in_data;
    end else begin : g_narrow
      assign ext = {{(64-W){in_data[W-1]}}, in_data[W-1:0]};
    end
  endgenerate

  assign ready = ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      val  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (drain) full <= 1'b0;
      if (in_valid && !full) begin
        full <= 1'b1;
        val  <= ext;
      end else if (in_valid && full) begin
        ovf  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsm_arbiter.sv
module tsm_arbiter #(
  parameter int unsigned N     = 4,
  parameter bit          RR    = 1'b0,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  input  logic             take,
  output logic             any,
  output logic [IDX_W-1:0] gidx
);
  logic [IDX_W-1:0] ptr;

  generate
    if (RR) begin : g_rr
      always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (take) ptr <= (int'(gidx) == int'(N) - 1) ? '0 : gidx + 1'b1;
      end
    end else begin : g_fixed
      assign ptr = '0;
    end
  endgenerate

  always_comb begin
    any  = 1'b0;
    gidx = '0;
    for (int k = 0; k < int'(N); k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= int'(N)) idx = idx - int'(N);
      if (!any && req[idx]) begin
        any  = 1'b1;
        gidx = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/tagged_sample_merger.sv
module tagged_sample_merger
  import tsm_pkg::*;
#(
  parameter int unsigned        NUM_CH     = 4,
  parameter logic [NUM_CH*7-1:0] CH_WIDTHS = {7'd64, 7'd32, 7'd24, 7'd16},
  parameter int unsigned        LOW_ID_OFS = 128,
  parameter bit                 ARB_RR     = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CH-1:0]    ch_valid,
  output logic [NUM_CH-1:0]    ch_ready,
  input  logic [NUM_CH*64-1:0] ch_data,
  input  logic                 pps_in,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [63:0]          out_data,
  output logic [NUM_CH-1:0]    ovf
);
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  function automatic logic [NUM_CH-1:0] wide_mask();
    logic [NUM_CH-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NUM_CH); i++)
      m[i] = (CH_WIDTHS[i*WIDTH_FIELD_W +: WIDTH_FIELD_W] == 7'd64);
    return m;
  endfunction

  localparam logic [NUM_CH-1:0] WIDE = wide_mask();

  logic [NUM_CH-1:0] slot_full;
  logic [NUM_CH-1:0] drain;
  logic [63:0]       slot_val [NUM_CH];
  logic              any;
  logic [IDX_W-1:0]  gidx;
  logic              load_en;
  logic              take;
  logic              pps_pend;
  logic              pps_taken;
  logic [HALF_W-1:0] pps_count;
  logic              lo_pend;
  tagged_word_t      lo_word;
  tagged_word_t      word_q;
  logic [63:0]       sel_val;
  logic [HALF_W-1:0] sel_tag;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_slot
      tsm_slot #(.W(int'(CH_WIDTHS[g*WIDTH_FIELD_W +: WIDTH_FIELD_W]))) slot_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (ch_valid[g]),
        .in_data  (ch_data[g*64 +: 64]),
        .drain    (drain[g]),
        .ready    (ch_ready[g]),
        .full     (slot_full[g]),
        .val      (slot_val[g]),
        .ovf      (ovf[g])
      );
    end
  endgenerate

  tsm_arbiter #(.N(NUM_CH), .RR(ARB_RR), .IDX_W(IDX_W)) arb_i (
    .clk  (clk),
    .rst  (rst),
    .req  (slot_full),
    .take (take),
    .any  (any),
    .gidx (gidx)
  );

  tsm_pps_detect #(.CNT_W(HALF_W)) pps_i (
    .clk    (clk),
    .rst    (rst),
    .pps_in (pps_in),
    .taken  (pps_taken),
    .pend   (pps_pend),
    .count  (pps_count)
  );

  assign load_en   = !out_valid || out_ready;
  assign pps_taken = load_en && !lo_pend && pps_pend;
  assign take      = load_en && !lo_pend && !pps_pend && any;
  assign drain     = take ? (NUM_CH'(1) << gidx) : '0;
  assign sel_val   = slot_val[gidx];
  assign sel_tag   = HALF_W'(gidx) + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      word_q    <= '0;
      lo_pend   <= 1'b0;
      lo_word   <= '0;
    end else if (load_en) begin
      if (lo_pend) begin
        out_valid <= 1'b1;
        word_q    <= lo_word;
        lo_pend   <= 1'b0;
      end else if (pps_pend) begin
        out_valid <= 1'b1;
        word_q    <= '{tag: '0, value: pps_count};
      end else if (any) begin
        out_valid <= 1'b1;
        if (WIDE[gidx]) begin
          word_q  <= '{tag: sel_tag, value: sel_val[63:32]};
          lo_word <= '{tag: sel_tag + HALF_W'(LOW_ID_OFS), value: sel_val[31:0]};
          lo_pend <= 1'b1;
        end else begin
          word_q  <= '{tag: sel_tag, value: sel_val[31:0]};
        end
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_data = word_q;
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
  parameter int unsigned        NUM_CH     = 4,
  parameter logic [NUM_CH*7-1:0] CH_WIDTHS = {7'd64, 7'd32, 7'd24, 7'd16},
  parameter int unsigned        LOW_ID_OFS = 128
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_valid,
  input logic [NUM_CH-1:0] ch_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [63:0]       out_data,
  input logic [NUM_CH-1:0] ovf
);
  logic hi_tag;
  logic tag_ok;

  always_comb begin
    hi_tag = 1'b0;
    tag_ok = (out_data[63:32] == 32'd0);
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (out_data[63:32] == 32'(i + 1)) begin
        tag_ok = 1'b1;
        if (CH_WIDTHS[i*7 +: 7] == 7'd64) hi_tag = 1'b1;
      end
      if (CH_WIDTHS[i*7 +: 7] == 7'd64 && out_data[63:32] == 32'(i + 1) + 32'(LOW_ID_OFS))
        tag_ok = 1'b1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11

  AST_LOW_FOLLOWS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && hi_tag) |=>
      (out_valid && out_data[63:32] == $past(out_data[63:32]) + 32'(LOW_ID_OFS))); // R4

  AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> tag_ok); // R2

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf[g] |=> ovf[g]); // R10
      AST_ACCEPT_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (ch_valid[g] && ch_ready[g] && !ovf[g]) |=> !ovf[g]); // R9
    end
  endgenerate
endmodule

bind tagged_sample_merger tsm_checker #(
  .NUM_CH(NUM_CH), .CH_WIDTHS(CH_WIDTHS), .LOW_ID_OFS(LOW_ID_OFS)
) chk_i (
  .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_ready(ch_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .ovf(ovf)
);

// File: tb/tagged_sample_merger_tb_top.sv
module tagged_sample_merger_tb_top;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH-1:0]  ch_valid = '0;
  logic [NCH*64-1:0] ch_data = '0;
  logic            pps_in = 1'b0;
  logic            out_ready = 1'b1;

  logic [NCH-1:0]  rdy_f, rdy_r, ovf_f, ovf_r;
  logic            ov_f, ov_r;
  logic [63:0]     od_f, od_r;

  logic [63:0] q_f[$];
  logic [63:0] q_r[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tagged_sample_merger #(.ARB_RR(1'b0)) dut_i (
    .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_ready(rdy_f), .ch_data(ch_data),
    .pps_in(pps_in), .out_valid(ov_f), .out_ready(out_ready), .out_data(od_f), .ovf(ovf_f));

  tagged_sample_merger #(.ARB_RR(1'b1)) dut_rr_i (
    .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_ready(rdy_r), .ch_data(ch_data),
    .pps_in(pps_in), .out_valid(ov_r), .out_ready(out_ready), .out_data(od_r), .ovf(ovf_r));

  always @(posedge clk) begin
    if (!rst) begin
      if (ov_f && out_ready) q_f.push_back(od_f);
      if (ov_r && out_ready) q_r.push_back(od_r);
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] wf(int i);
    if (i < q_f.size()) return q_f[i];
    return 64'hx;
  endfunction

  function automatic logic [63:0] wr(int i);
    if (i < q_r.size()) return q_r[i];
    return 64'hx;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ch_valid = '0; pps_in = 1'b0; out_ready = 1'b1;
    idle(3);
    rst = 1'b0;
    q_f.delete(); q_r.delete();
  endtask

  task automatic push(int ch, logic [63:0] d);
    @(negedge clk);
    ch_valid[ch] = 1'b1;
    ch_data[ch*64 +: 64] = d;
    @(negedge clk);
    ch_valid = '0;
  endtask

  task automatic pulse(int len);
    @(negedge clk);
    pps_in = 1'b1;
    idle(len);
    pps_in = 1'b0;
    idle(6);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    chk("R1 out_valid in reset", 64'(ov_f), 64'd0);
    chk("R1 ch_ready in reset", 64'(rdy_f), 64'hF);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ovf after reset", 64'(ovf_f), 64'd0);
    chk("R1 out_valid after reset", 64'(ov_f), 64'd0);
  endtask

  task automatic t_narrow();
    do_reset();
    push(0, 64'hABCD_0000_1234_8001);
    idle(6);
    push(1, 64'h5555_0000_FF7F_FFFF);
    idle(6);
    push(2, 64'hFFFF_FFFF_8000_0000);
    idle(6);
    push(0, 64'h0000_0000_FFFF_7FFE);
    idle(6);
    chk("R3 16-bit negative sign extension", wf(0), 64'h0000_0001_FFFF_8001);
    chk("R3 24-bit positive, upper bits ignored", wf(1), 64'h0000_0002_007F_FFFF);
    chk("R2 32-bit passed with tag 3", wf(2), 64'h0000_0003_8000_0000);
    chk("R3 16-bit positive", wf(3), 64'h0000_0001_0000_7FFE);
    chk("R9 narrow word count", 64'(q_f.size()), 64'd4);
  endtask

  task automatic t_wide_and_marker();
    do_reset();
    out_ready = 1'b0;
    push(3, 64'h1122_3344_5566_7788);
    idle(3);
    pulse(2);
    push(0, 64'h0000_0000_0000_0042);
    idle(3);
    out_ready = 1'b1;
    idle(10);
    chk("R4 high half first", wf(0), 64'h0000_0004_1122_3344);
    chk("R4 low half next, R6 marker waits", wf(1), 64'h0000_0084_5566_7788);
    chk("R6 marker before channel 0", wf(2), 64'h0000_0000_0000_0001);
    chk("R6 channel 0 last", wf(3), 64'h0000_0001_0000_0042);
  endtask

  task automatic t_marker();
    do_reset();
    out_ready = 1'b0;
    push(0, 64'h0000_0000_0000_00A1);
    idle(3);
    push(1, 64'h0000_0000_0000_00B2);
    pulse(2);
    chk("R11 held valid", 64'(ov_f), 64'd1);
    chk("R11 held data", od_f, 64'h0000_0001_0000_00A1);
    out_ready = 1'b1;
    idle(8);
    pulse(20);
    idle(6);
    chk("R6 stalled word first", wf(0), 64'h0000_0001_0000_00A1);
    chk("R6 marker overtakes ch1", wf(1), 64'h0000_0000_0000_0001);
    chk("R6 ch1 after marker", wf(2), 64'h0000_0002_0000_00B2);
    chk("R5 second marker count", wf(3), 64'h0000_0000_0000_0002);
    chk("R5 long pulse gives one marker", 64'(q_f.size()), 64'd4);
  endtask

  task automatic t_fixed_order();
    do_reset();
    out_ready = 1'b0;
    @(negedge clk);
    ch_valid = 4'hF;
    ch_data = {64'h0000_0004_0000_0005, 64'h0000_0000_0000_0033,
               64'h0000_0000_0000_0022, 64'h0000_0000_0000_0011};
    @(negedge clk);
    ch_valid = '0;
    idle(4);
    out_ready = 1'b1;
    idle(12);
    chk("R7 first ch0", wf(0), 64'h0000_0001_0000_0011);
    chk("R7 second ch1", wf(1), 64'h0000_0002_0000_0022);
    chk("R7 third ch2", wf(2), 64'h0000_0003_0000_0033);
    chk("R7 fourth ch3 high", wf(3), 64'h0000_0004_0000_0004);
    chk("R7 fifth ch3 low", wf(4), 64'h0000_0084_0000_0005);
  endtask

  task automatic t_round_robin();
    do_reset();
    out_ready = 1'b0;
    @(negedge clk);
    ch_valid = 4'h3;
    ch_data[63:0] = 64'h0000_0000_0000_00C0;
    ch_data[127:64] = 64'h0000_0000_0000_00D0;
    @(negedge clk);
    ch_valid = '0;
    idle(4);
    push(0, 64'h0000_0000_0000_00C1);
    idle(3);
    out_ready = 1'b1;
    idle(10);
    chk("R7 fixed: ch0 first", wf(0), 64'h0000_0001_0000_00C0);
    chk("R7 fixed: ch0 again before ch1", wf(1), 64'h0000_0001_0000_00C1);
    chk("R7 fixed: ch1 last", wf(2), 64'h0000_0002_0000_00D0);
    chk("R8 rr: ch0 first", wr(0), 64'h0000_0001_0000_00C0);
    chk("R8 rr: ch1 after ch0", wr(1), 64'h0000_0002_0000_00D0);
    chk("R8 rr: ch0 wraps last", wr(2), 64'h0000_0001_0000_00C1);
  endtask

  task automatic t_overflow();
    do_reset();
    out_ready = 1'b0;
    chk("R9 ready when empty", 64'(rdy_f[0]), 64'd1);
    push(0, 64'h0000_0000_0000_0101);
    idle(3);
    push(0, 64'h0000_0000_0000_0202);
    idle(2);
    chk("R9 ready low when full", 64'(rdy_f[0]), 64'd0);
    chk("R10 no ovf yet", 64'(ovf_f), 64'd0);
    push(0, 64'h0000_0000_0000_0303);
    idle(2);
    chk("R10 only ch0 ovf set", 64'(ovf_f), 64'h1);
    out_ready = 1'b1;
    idle(10);
    chk("R10 word 0", wf(0), 64'h0000_0001_0000_0101);
    chk("R10 word 1", wf(1), 64'h0000_0001_0000_0202);
    chk("R10 discarded sample absent", 64'(q_f.size()), 64'd2);
    push(0, 64'h0000_0000_0000_0404);
    idle(6);
    chk("R10 ovf sticky", 64'(ovf_f), 64'h1);
    chk("R9 later sample accepted", wf(2), 64'h0000_0001_0000_0404);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(2);
    t_reset();
    t_narrow();
    t_wide_and_marker();
    t_marker();
    t_fixed_order();
    t_round_robin();
    t_overflow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule